// File: doc/BRIEF.md
# Address Acknowledge Timing Controller

This block decides in which cycle a system bridge raises address acknowledge for each address tenure on a processor bus. The bus allows one level of pipelining. A tenure begins with a transfer-start strobe. From that cycle on, the block holds acknowledge back until three things are true: the programmed wait states have run out, the retry window has closed, and any data tenure that was still running at transfer start has ended. It then gives exactly one acknowledge pulse.

The wait-state counts come from configuration inputs. The address wait is set by two fields, the cache-hit delay and the address-phase minimum, unless the bridge itself started the tenure. The retry window is set by a separate snoop field. A window output stays high for as long as a retry response may still be sampled. The controller does not decode addresses, does not snoop and does not move data. It only times the acknowledge.

Top module: `aack_timer`

## Requirements
- R1: For a processor-initiated tenure (`bridgeInit`=0) with `compatMode`=0, the effective address wait W is the larger of `hitDly` and `aphaseWs`.
- R2: The wait counters load in the transfer-start cycle (cycle 0) and count down once per clock. With no other hold-off, `aack` rises in cycle 1+max(W, `snoopWs`). When every field is zero, this is cycle 1.
- R3: If `dataBusy` is high in cycle 0 and `addrOnly` is 0, the tenure is pipelined. `aack` is then not given before the first cycle after cycle 0 in which `dataBusy` is low.
- R4: An address-only tenure (`addrOnly`=1) is never held back by `dataBusy`.
- R5: `retryWin` is high in cycles 0 through `snoopWs` (`snoopWs`+1 consecutive cycles) and low in every other cycle of the tenure, including the acknowledge cycle. `aack` never comes before the window closes.
- R6: For a bridge-initiated tenure (`bridgeInit`=1), W equals `snoopWs`. `hitDly`, `aphaseWs` and `compatMode` have no effect.
- R7: For a processor-initiated tenure with `compatMode`=1, W is the R1 value raised to at least 1.
- R8: Each accepted tenure produces exactly one single-cycle `aack` pulse.
- R9: A `tsValid` that arrives while a tenure is pending, including its acknowledge cycle, is ignored. It leaves the acknowledge timing and `retryWin` unchanged.
- R10: A synchronous `rst` clears the counters and any pending tenure. No `aack` follows for that tenure, and `retryWin` is low from the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tsValid | input | 1 | Transfer start for an address tenure |
| addrOnly | input | 1 | Transfer type carries no data tenure |
| bridgeInit | input | 1 | 1 = tenure started by the bridge, 0 = by the processor |
| dataBusy | input | 1 | A data tenure is in progress |
| compatMode | input | 1 | Memory-map compatibility mode forces a processor address wait of at least 1 |
| hitDly | input | WS_W | Cache-hit delay wait states |
| aphaseWs | input | WS_W | Minimum address-phase wait states |
| snoopWs | input | WS_W | Snoop wait states, the length of the retry window |
| aack | output | 1 | Address acknowledge, one-cycle pulse |
| retryWin | output | 1 | A retry may still be sampled |

## Verification
The assertions assume the configuration fields and `bridgeInit` stay stable from transfer start until acknowledge. They also assume that `dataBusy`, once it drops during a pipelined hold, is judged only in that cycle. The stimulus changes configuration only between tenures and leaves the bus idle long enough for every pulse to appear. Transfer starts that arrive during a pending tenure are injected on purpose, to show that they are ignored.

// File: rtl/aack_timer_pkg.sv
package aack_timer_pkg;
  typedef struct packed {
    logic load;   // capture wait values at transfer start
    logic count;  // decrement running counters
  } ctrl_strobe_t;

  localparam int NUM_CNT = 2;
  localparam int CNT_ADDR = 0;
  localparam int CNT_SNOOP = 1;
endpackage

// File: rtl/aack_timer_dp.sv
module aack_timer_dp
  import aack_timer_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_strobe_t    strobe,
  input  logic            bridgeInit,
  input  logic            compatMode,
  input  logic [WS_W-1:0] hitDly,
  input  logic [WS_W-1:0] aphaseWs,
  input  logic [WS_W-1:0] snoopWs,
  output logic            waitDone,
  output logic            snoopDone
);
  localparam logic [WS_W-1:0] ONE = WS_W'(1);

  logic [WS_W-1:0] procWait;
  logic [WS_W-1:0] effWait;
  logic [WS_W-1:0] loadVal [NUM_CNT];
  logic [WS_W-1:0] cntVal  [NUM_CNT];
  logic            cntZero [NUM_CNT];

  always_comb begin
    procWait = (hitDly > aphaseWs) ? hitDly : aphaseWs;
    if (compatMode && procWait == '0) procWait = ONE;
    effWait = bridgeInit ? snoopWs : procWait;
  end

  assign loadVal[CNT_ADDR]  = effWait;
  assign loadVal[CNT_SNOOP] = snoopWs;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cntVal[i] <= '0;
      end else if (strobe.load) begin
        cntVal[i] <= loadVal[i];
      end else if (strobe.count && cntVal[i] != '0) begin
        cntVal[i] <= cntVal[i] - ONE;
      end
    end
    assign cntZero[i] = (cntVal[i] == '0);
  end

  assign waitDone  = cntZero[CNT_ADDR];
  assign snoopDone = cntZero[CNT_SNOOP];

  AST_PROC_WAIT_MAX: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !bridgeInit) |=>
      (cntVal[CNT_ADDR] >= $past(hitDly) && cntVal[CNT_ADDR] >= $past(aphaseWs))); // R1

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (strobe.count && !strobe.load && cntVal[CNT_ADDR] != '0) |=>
      (cntVal[CNT_ADDR] == $past(cntVal[CNT_ADDR]) - ONE)); // R2

  AST_BRIDGE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && bridgeInit) |=> (cntVal[CNT_ADDR] == $past(snoopWs))); // R6

  AST_COMPAT_MIN: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !bridgeInit && compatMode) |=> (cntVal[CNT_ADDR] != '0)); // R7
endmodule

// File: rtl/aack_timer_ctrl.sv
module aack_timer_ctrl
  import aack_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         tsValid,
  input  logic         addrOnly,
  input  logic         dataBusy,
  input  logic         waitDone,
  input  logic         snoopDone,
  output ctrl_strobe_t strobe,
  output logic         aack,
  output logic         retryWin
);
  logic active;
  logic pipeHold;
  logic accept;
  logic ackNow;

  assign accept = tsValid && !active;
  assign ackNow = active && waitDone && snoopDone && !(pipeHold && dataBusy);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      pipeHold <= 1'b0;
    end else if (accept) begin
      active   <= 1'b1;
      pipeHold <= dataBusy && !addrOnly;
    end else begin
      if (ackNow) active <= 1'b0;
      if (ackNow || !dataBusy) pipeHold <= 1'b0;
    end
  end

  always_comb begin
    strobe.load  = accept;
    strobe.count = active;
  end

  assign aack     = ackNow;
  assign retryWin = accept || (active && !snoopDone);

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    aack |=> !aack); // R8
endmodule

// File: rtl/aack_timer.sv
module aack_timer
  import aack_timer_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tsValid,
  input  logic            addrOnly,
  input  logic            bridgeInit,
  input  logic            dataBusy,
  input  logic            compatMode,
  input  logic [WS_W-1:0] hitDly,
  input  logic [WS_W-1:0] aphaseWs,
  input  logic [WS_W-1:0] snoopWs,
  output logic            aack,
  output logic            retryWin
);
  ctrl_strobe_t strobe;
  logic         waitDone;
  logic         snoopDone;

  aack_timer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tsValid   (tsValid),
    .addrOnly  (addrOnly),
    .dataBusy  (dataBusy),
    .waitDone  (waitDone),
    .snoopDone (snoopDone),
    .strobe    (strobe),
    .aack      (aack),
    .retryWin  (retryWin)
  );

  aack_timer_dp #(.WS_W(WS_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .bridgeInit (bridgeInit),
    .compatMode (compatMode),
    .hitDly     (hitDly),
    .aphaseWs   (aphaseWs),
    .snoopWs    (snoopWs),
    .waitDone   (waitDone),
    .snoopDone  (snoopDone)
  );

  AST_WIN_LOW_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    aack |-> !retryWin); // R5
endmodule

// File: tb/aack_timer_tb.sv
module aack_timer_tb;
  localparam int WS_W = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic tsValid = 1'b0, addrOnly = 1'b0, bridgeInit = 1'b0, dataBusy = 1'b0, compatMode = 1'b0;
  logic [WS_W-1:0] hitDly = '0, aphaseWs = '0, snoopWs = '0;
  logic aack, retryWin;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  aack_timer #(.WS_W(WS_W)) u_dut (
    .clk(clk), .rst(rst), .tsValid(tsValid), .addrOnly(addrOnly),
    .bridgeInit(bridgeInit), .dataBusy(dataBusy), .compatMode(compatMode),
    .hitDly(hitDly), .aphaseWs(aphaseWs), .snoopWs(snoopWs),
    .aack(aack), .retryWin(retryWin)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effWait(int h, int a, int s, bit c, bit b);
    int w;
    if (b) return s;
    w = (h > a) ? h : a;
    if (c && w == 0) w = 1;
    return w;
  endfunction

  // Called at posedge+1; cycle 0 is the transfer-start cycle.
  task automatic runCase(int h, int a, int s, bit c, bit b, bit ao,
                         int busyLen, bit extraTs, string req);
    int ackAt = -1;
    int pulses = 0;
    int winCnt = 0;
    int winLast = -1;
    int winAtAck = 0;
    int winGap = 0;
    int exp;
    hitDly = WS_W'(h); aphaseWs = WS_W'(a); snoopWs = WS_W'(s);
    compatMode = c; bridgeInit = b; addrOnly = ao;
    for (int cyc = 0; cyc < 16; cyc++) begin
      tsValid  = (cyc == 0) || (extraTs && cyc == 2);
      dataBusy = (cyc < busyLen);
      #3;
      if (aack) begin
        pulses++;
        if (ackAt < 0) ackAt = cyc;
        if (retryWin) winAtAck = 1;
      end
      if (retryWin) begin
        if (winLast != cyc - 1) winGap = 1;
        winLast = cyc;
        winCnt++;
      end
      @(posedge clk); #1;
    end
    tsValid = 1'b0; dataBusy = 1'b0; addrOnly = 1'b0;
    exp = 1 + effWait(h, a, s, c, b);
    if (1 + s > exp) exp = 1 + s;
    if (!ao && busyLen > 0 && busyLen > exp) exp = busyLen;
    check(ackAt == exp, req, "ack cycle", ackAt, exp);
    check(pulses == 1, "R8", "ack pulse count", pulses, 1);
    check(winCnt == s + 1, "R5", "retry window length", winCnt, s + 1);
    check(winGap == 0, "R5", "retry window gap", winGap, 0);
    check(winAtAck == 0, "R5", "window high at ack", winAtAck, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #3;
    check(aack == 1'b0, "R10", "aack after reset", aack, 0);
    check(retryWin == 1'b0, "R10", "retryWin after reset", retryWin, 0);
    @(posedge clk); #1;

    // R2: all-zero configuration acknowledges in the next cycle
    runCase(0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // Full sweep of the small configuration space
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 2; c++)
        for (int h = 0; h < 4; h++)
          for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
              runCase(h, a, s, c[0], b[0], 0, 0, 0,
                      b ? "R6" : (c ? "R7" : "R1"));

    // R3: pipelined tenures held until the data tenure ends
    for (int bl = 1; bl < 9; bl++)
      for (int s = 0; s < 4; s += 3)
        runCase(1, 0, s, 0, 0, 0, bl, 0, "R3");
    runCase(0, 2, 1, 0, 1, 0, 7, 0, "R3");

    // R4: address-only tenures ignore dataBusy
    for (int bl = 1; bl < 9; bl += 3)
      runCase(0, 1, 0, 0, 0, 1, bl, 0, "R4");

    // R9: transfer start during a pending tenure is ignored
    runCase(3, 0, 0, 0, 0, 0, 0, 1, "R9");
    runCase(0, 0, 1, 0, 0, 0, 0, 1, "R9");
    runCase(0, 0, 0, 0, 0, 0, 5, 1, "R9");

    // R10: reset in the middle of a tenure
    hitDly = 3'd0; aphaseWs = 3'd0; snoopWs = 3'd3; bridgeInit = 0; compatMode = 0;
    tsValid = 1'b1;
    @(posedge clk); #1;
    tsValid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int cyc = 0; cyc < 8; cyc++) begin
      #3;
      check(aack == 1'b0, "R10", "aack after mid-tenure reset", aack, 0);
      check(retryWin == 1'b0, "R10", "retryWin after mid-tenure reset", retryWin, 0);
      @(posedge clk); #1;
    end
    runCase(2, 1, 1, 0, 0, 0, 0, 0, "R10");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule